// File: doc/BRIEF.md
# PHY Interrupt Source and Mask Controller

This block gathers seven single-cycle event pulses from a PHY, such as a link loss or the end of auto-negotiation, into a latched flag register. A mask register with the same bit layout decides which latched flags reach the single interrupt line sent to the system interrupt controller. Once an event pulse sets its flag, the flag stays set until the host reads the flag register. That read returns the flags and clears them in the same access.

Host access goes through a small synchronous register port. The port has an address, a read strobe, a write strobe, write data and read data. Read data is combinational from the address while the read strobe is high, so every access completes in one clock cycle.

The flag register sits at address 29 and the mask register at address 30. Any other address reads as all ones. Power-down activity elsewhere in the PHY does not touch these registers, because only the block's own reset clears them.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset is asserted, both the flag register and the mask register read as 16'h0000, and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[k]` sets flag bit k+1 on the next clock edge. The bits are: 7 energy-on, 6 auto-negotiation complete, 5 remote fault, 4 link down, 3 link-partner acknowledge, 2 parallel detection fault, 1 page received. The flag then stays set until a clearing read.
- R3: A read at address 29 returns the flags in bits 7:1 with bits 15:8 and 0 at zero, and clears every flag on that clock edge.
- R4: An event pulse in the same cycle as a clearing read leaves its flag set after that edge.
- R5: A write at address 30 stores `reg_wdata[7:1]` into the mask. A read at address 30 returns the mask in bits 7:1 with bits 15:8 and 0 at zero.
- R6: `irq_o` is high in the same cycle exactly when some flag bit and its matching mask bit are both set.
- R7: Clearing a mask bit drops that bit's contribution to `irq_o` but leaves the latched flag unchanged.
- R8: A write at address 29 changes no flag.
- R9: A read at any address other than 29 or 30 returns 16'hFFFF.
- R10: `reg_rdata` is 16'h0000 whenever `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| evt_i | input | 7 | Event pulses; bit k sets flag bit k+1 |
| reg_addr | input | 5 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Aggregated masked interrupt |

## Verification
A flag that is wrongly set, wrongly kept or wrongly lost shows up at the ports in two ways. `irq_o` disagrees within the same cycle whenever the matching mask bit is on, and the next read of address 29 returns the wrong value. A bad mask bit is seen both on `irq_o` and on a read of address 30. Because every state bit reaches a port within one cycle, the bench compares the ports against a reference model on every cycle. The random stimulus turns the mask over often enough that each flag bit is exposed through `irq_o`.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned N_EVT    = 7;
  localparam int unsigned EVT_LSB  = 1;
  localparam logic [ADDR_W-1:0] SRC_ADDR = ADDR_W'(29);
  localparam logic [ADDR_W-1:0] MSK_ADDR = ADDR_W'(30);
  localparam logic [DATA_W-1:0] UNIMPL_VAL = '1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SRC  = 2'd1,
    SEL_MSK  = 2'd2,
    SEL_BAD  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/phy_irq_src_latch.sv
module phy_irq_src_latch #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, flags_d;
  logic         flags_en;

  always_comb begin
    flags_en = clr_i | (|evt_i);
    // events win over the clear so nothing is lost
    flags_d  = (flags_q & ~{N{clr_i}}) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));
  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> (flags_q == '0));
  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/phy_irq_mask_reg.sv
module phy_irq_mask_reg #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q, mask_d;

  always_comb mask_d = wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_en_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R5
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mask_q == $past(wdata_i)));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mask_q));
endmodule

// File: rtl/phy_irq_regmux.sv
module phy_irq_regmux
  import phy_irq_pkg::*;
#(
  parameter int unsigned N   = N_EVT,
  parameter int unsigned LSB = EVT_LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [N-1:0]      flags_i,
  input  logic [N-1:0]      mask_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              src_clr_o,
  output logic              msk_wr_o
);
  localparam int unsigned MSB = LSB + N - 1;

  reg_sel_e          sel;
  logic [DATA_W-1:0] src_word, msk_word;

  always_comb begin
    if (addr_i == SRC_ADDR)      sel = SEL_SRC;
    else if (addr_i == MSK_ADDR) sel = SEL_MSK;
    else                         sel = SEL_BAD;
  end

  // place the N-bit fields, reserved bits forced to zero
  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_field
      if (g >= LSB && g <= MSB) begin : g_live
        assign src_word[g] = flags_i[g-LSB];
        assign msk_word[g] = mask_i[g-LSB];
      end else begin : g_rsvd
        assign src_word[g] = 1'b0;
        assign msk_word[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel)
        SEL_SRC: rdata_o = src_word;
        SEL_MSK: rdata_o = msk_word;
        default: rdata_o = UNIMPL_VAL;
      endcase
    end
  end

  assign src_clr_o = rd_i & (sel == SEL_SRC);
  assign msk_wr_o  = wr_i & (sel == SEL_MSK);
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [N_EVT-1:0] flags, mask;
  logic             src_clr, msk_wr;

  phy_irq_regmux #(.N(N_EVT), .LSB(EVT_LSB)) u_mux (
    .addr_i   (reg_addr),
    .rd_i     (reg_rd),
    .wr_i     (reg_wr),
    .flags_i  (flags),
    .mask_i   (mask),
    .rdata_o  (reg_rdata),
    .src_clr_o(src_clr),
    .msk_wr_o (msk_wr)
  );

  phy_irq_src_latch #(.N(N_EVT)) u_src (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .clr_i  (src_clr),
    .flags_o(flags)
  );

  phy_irq_mask_reg #(.N(N_EVT)) u_msk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en_i(msk_wr),
    .wdata_i(reg_wdata[EVT_LSB +: N_EVT]),
    .mask_o (mask)
  );

  assign irq_o = |(flags & mask);

  // R8
  src_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SRC_ADDR && !reg_rd && evt_i == '0) |=> $stable(flags));
  // R9
  unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr != SRC_ADDR && reg_addr != MSK_ADDR) |-> (reg_rdata == 16'hFFFF));
  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0));
endmodule

// File: tb/phy_irq_ctrl_tb.sv
module phy_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  evt_i;
  logic [4:0]  reg_addr;
  logic        reg_rd, reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq_o;

  int n_run  = 0;
  int n_fail = 0;
  logic [6:0] m_flags, m_mask;

  always #5 clk = ~clk;

  phy_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic [15:0] exp_rdata(logic rd, logic [4:0] a);
    if (!rd) return 16'h0000;
    if (a == 5'd29) return {8'h00, m_flags, 1'b0};
    if (a == 5'd30) return {8'h00, m_mask, 1'b0};
    return 16'hFFFF;
  endfunction

  function automatic string rd_tag(logic rd, logic [4:0] a);
    if (!rd) return "R10";
    if (a == 5'd29) return "R3";
    if (a == 5'd30) return "R5";
    return "R9";
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access cycle: inputs driven after negedge, combinational checks, model update at edge
  task automatic cyc(logic [6:0] e, logic [4:0] a, logic rd, logic wr, logic [15:0] wd);
    evt_i = e; reg_addr = a; reg_rd = rd; reg_wr = wr; reg_wdata = wd;
    #1;
    chk(rd_tag(rd, a), reg_rdata, exp_rdata(rd, a));
    chk("R6", {15'd0, irq_o}, {15'd0, |(m_flags & m_mask)});
    @(posedge clk);
    if (rd && a == 5'd29) m_flags = '0;
    m_flags = m_flags | e;
    if (wr && a == 5'd30) m_mask = wd[7:1];
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(7'd0, 5'd0, 1'b0, 1'b0, 16'd0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; evt_i = '0; reg_addr = '0; reg_rd = 0; reg_wr = 0; reg_wdata = '0;
    m_flags = '0; m_mask = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    reg_addr = 5'd30; reg_rd = 1'b1; #1;
    chk("R1", reg_rdata, 16'h0000);
    chk("R1", {15'd0, irq_o}, 16'h0000);
    reg_rd = 1'b0;
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R2: each event sets its bit and holds
    for (int k = 0; k < 7; k++) begin
      cyc(7'(1 << k), 5'd0, 1'b0, 1'b0, 16'd0);
      idle();
      cyc(7'd0, 5'd29, 1'b1, 1'b0, 16'd0);
      chk("R2", {9'd0, m_flags}, 16'd0);
    end
    // R2 hold across idle cycles, then read
    cyc(7'b1000000, 5'd0, 1'b0, 1'b0, 16'd0);
    repeat (5) idle();
    reg_addr = 5'd29; reg_rd = 1'b1; #1;
    chk("R2", reg_rdata, 16'h0080);
    reg_rd = 1'b0; reg_addr = 5'd0; #1;
    cyc(7'd0, 5'd29, 1'b1, 1'b0, 16'd0);

    // R4: event coincident with clearing read survives
    cyc(7'b0000011, 5'd0, 1'b0, 1'b0, 16'd0);
    cyc(7'b0000100, 5'd29, 1'b1, 1'b0, 16'd0);
    reg_addr = 5'd29; reg_rd = 1'b1; #1;
    chk("R4", reg_rdata, 16'h0008);
    reg_rd = 1'b0; #1;
    cyc(7'd0, 5'd29, 1'b1, 1'b0, 16'd0);

    // R5: reserved bits dropped on mask write
    cyc(7'd0, 5'd30, 1'b0, 1'b1, 16'hFFFF);
    reg_addr = 5'd30; reg_rd = 1'b1; #1;
    chk("R5", reg_rdata, 16'h00FE);
    reg_rd = 1'b0; #1;

    // R7: mask clear drops irq, flag kept
    cyc(7'b0010000, 5'd0, 1'b0, 1'b0, 16'd0);
    #1 chk("R7", {15'd0, irq_o}, 16'd1);
    cyc(7'd0, 5'd30, 1'b0, 1'b1, 16'h0000);
    #1 chk("R7", {15'd0, irq_o}, 16'd0);
    reg_addr = 5'd29; reg_rd = 1'b1; #1;
    chk("R7", reg_rdata, 16'h0020);
    reg_rd = 1'b0; #1;

    // R8: write to flag register ignored
    cyc(7'd0, 5'd29, 1'b0, 1'b1, 16'hFFFF);
    cyc(7'd0, 5'd29, 1'b0, 1'b1, 16'h0000);
    reg_addr = 5'd29; reg_rd = 1'b1; #1;
    chk("R8", reg_rdata, 16'h0020);
    reg_rd = 1'b0; #1;
    cyc(7'd0, 5'd29, 1'b1, 1'b0, 16'd0);

    // R9: unimplemented addresses
    for (int a = 0; a < 32; a++)
      if (a != 29 && a != 30) cyc(7'd0, 5'(a), 1'b1, 1'b0, 16'd0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] e;
      logic [4:0] a;
      int pick;
      e = 7'($urandom & $urandom & $urandom);
      pick = $urandom_range(0, 9);
      a = (pick < 4) ? 5'd29 : (pick < 7) ? 5'd30 : 5'($urandom);
      cyc(e, a, ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0), 16'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule